// File: doc/BRIEF.md
# Dual-Bank Paired Register File

This block is the general-purpose register storage of an 8-bit processor core. It holds eight working registers (an accumulator, a flag register and six general registers B, C, D, E, H, L) and a second, shadow copy of each. Software-visible access always goes to whichever copy is currently selected. The shadow copy can only be reached by swapping it into view.

Reads are combinational. One read port returns a single byte by register code, and the other returns a 16-bit pair by pair code. Both write ports commit on the rising clock edge. One takes a byte by register code and the other takes a 16-bit pair by pair code.

There are two exchange commands. One swaps the accumulator/flag pair between its two copies. The other swaps all three general pairs together. Each command toggles a bank-select bit instead of moving data, so a swap takes effect on the next edge. The decode and ALU logic drive the ports directly every cycle.

Top module: `dual_bank_regfile`

## Requirements
- R1: The 8-bit read port returns the visible copy of the register named by its 3-bit code (0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=A, 7=F). With no write and no exchange, a read value does not change.
- R2: The 16-bit read port returns the visible pair named by its 2-bit code (0=BC, 1=DE, 2=HL, 3=AF). The first-named register is bits 15:8 and the second is bits 7:0. Register code bits 2:1 give the pair and bit 0 gives the low byte.
- R3: An 8-bit write updates the addressed visible register at the clock edge, and the new value is readable right after that edge.
- R4: A 16-bit write updates both bytes of the addressed visible pair at the clock edge.
- R5: If an 8-bit write and a 16-bit write target the same register in one cycle, the register takes the byte from the 16-bit write.
- R6: The general exchange command swaps BC, DE and HL with their shadow copies in one clock. The AF pair is not affected.
- R7: The accumulator exchange command swaps only AF with its shadow copy. The general pairs are not affected. Both commands may be given in the same cycle.
- R8: A write that arrives in the same cycle as an exchange goes to the copy that was visible before the swap.
- R9: Synchronous active-high reset makes the primary copy of every pair visible. Register contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the bank selects |
| rd8_sel | input | 3 | Register code for the byte read |
| rd8_data | output | 8 | Byte read data |
| rd16_sel | input | 2 | Pair code for the word read |
| rd16_data | output | 16 | Pair read data, high register in 15:8 |
| wr8_en | input | 1 | Byte write enable |
| wr8_sel | input | 3 | Register code for the byte write |
| wr8_data | input | 8 | Byte write data |
| wr16_en | input | 1 | Pair write enable |
| wr16_sel | input | 2 | Pair code for the pair write |
| wr16_data | input | 16 | Pair write data |
| xchg_af | input | 1 | Swap AF with its shadow copy |
| xchg_gen | input | 1 | Swap BC, DE and HL with their shadow copies |

## Verification
The assertions check several rules on every cycle: a plain write shows up on the matching read port after the edge, the wide write wins a collision, the byte and pair ports agree whenever they name the same pair, an idle cycle leaves read data unchanged, and each exchange command flips exactly its own bank select. Other behaviours need the bench's scripted sequences. These are that an exchange actually reveals the older shadow contents, that the other pairs keep their data, that a write given together with a swap lands in the hidden copy, and that after reset the primary data is visible again.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_REGS  = 8;
    localparam int NUM_BANKS = 2;
    localparam int CODE_W    = $clog2(NUM_REGS);
    localparam int PAIR_W    = CODE_W - 1;
    localparam int WIDE_W    = 2 * DATA_W;

    typedef enum logic [CODE_W-1:0] {
        REG_B = 3'd0, REG_C = 3'd1, REG_D = 3'd2, REG_E = 3'd3,
        REG_H = 3'd4, REG_L = 3'd5, REG_A = 3'd6, REG_F = 3'd7
    } reg_code_e;

    typedef enum logic [PAIR_W-1:0] {
        PAIR_BC = 2'd0, PAIR_DE = 2'd1, PAIR_HL = 2'd2, PAIR_AF = 2'd3
    } pair_code_e;

    typedef struct packed {
        logic acc;
        logic gen;
    } bank_sel_t;

    function automatic logic [PAIR_W-1:0] pair_of(input logic [CODE_W-1:0] code);
        return code[CODE_W-1:1];
    endfunction

    function automatic logic [CODE_W-1:0] high_code(input logic [PAIR_W-1:0] pair);
        return {pair, 1'b0};
    endfunction

    function automatic logic [CODE_W-1:0] low_code(input logic [PAIR_W-1:0] pair);
        return {pair, 1'b1};
    endfunction

    function automatic logic owner_bank(input logic [CODE_W-1:0] code,
                                        input bank_sel_t sel);
        return (pair_of(code) == PAIR_AF) ? sel.acc : sel.gen;
    endfunction

    function automatic logic [DATA_W-1:0] wide_byte(input logic [WIDE_W-1:0] word,
                                                    input logic [CODE_W-1:0] code);
        return code[0] ? word[DATA_W-1:0] : word[WIDE_W-1:DATA_W];
    endfunction

endpackage

// File: rtl/rfb_bank_select.sv
module rfb_bank_select
    import rfb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      xchg_af,
    input  logic      xchg_gen,
    output bank_sel_t sel_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            sel_q.acc <= sel_q.acc ^ xchg_af;
            sel_q.gen <= sel_q.gen ^ xchg_gen;
        end
    end

endmodule

// File: rtl/rfb_storage.sv
module rfb_storage
    import rfb_pkg::*;
(
    input  logic              clk,
    input  bank_sel_t         sel,
    input  logic              wr8_en,
    input  logic [CODE_W-1:0] wr8_sel,
    input  logic [DATA_W-1:0] wr8_data,
    input  logic              wr16_en,
    input  logic [PAIR_W-1:0] wr16_sel,
    input  logic [WIDE_W-1:0] wr16_data,
    input  logic [CODE_W-1:0] rd8_sel,
    output logic [DATA_W-1:0] rd8_data,
    input  logic [PAIR_W-1:0] rd16_sel,
    output logic [WIDE_W-1:0] rd16_data
);

    localparam int CELLS = NUM_BANKS * NUM_REGS;
    localparam int IDX_W = $clog2(CELLS);

    logic [CELLS-1:0][DATA_W-1:0] cell_view;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            localparam logic [CODE_W-1:0] CODE = CODE_W'(r);
            logic              hit_wide;
            logic              hit_byte;
            logic              owns;
            logic [DATA_W-1:0] q;

            always_comb begin
                hit_wide = wr16_en && (wr16_sel == pair_of(CODE));
                hit_byte = wr8_en && (wr8_sel == CODE);
                owns     = (owner_bank(CODE, sel) == 1'(b));
            end

            always_ff @(posedge clk) begin
                if (owns && hit_wide) begin
                    q <= wide_byte(wr16_data, CODE);
                end else if (owns && hit_byte) begin
                    q <= wr8_data;
                end
            end

            assign cell_view[b*NUM_REGS + r] = q;
        end
    end

    logic [IDX_W-1:0] idx8, idx_hi, idx_lo;

    always_comb begin
        idx8   = {owner_bank(rd8_sel, sel), rd8_sel};
        idx_hi = {owner_bank(high_code(rd16_sel), sel), high_code(rd16_sel)};
        idx_lo = {owner_bank(low_code(rd16_sel), sel), low_code(rd16_sel)};
        rd8_data  = cell_view[idx8];
        rd16_data = {cell_view[idx_hi], cell_view[idx_lo]};
    end

endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
    import rfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] rd8_sel,
    output logic [DATA_W-1:0] rd8_data,
    input  logic [PAIR_W-1:0] rd16_sel,
    output logic [WIDE_W-1:0] rd16_data,
    input  logic              wr8_en,
    input  logic [CODE_W-1:0] wr8_sel,
    input  logic [DATA_W-1:0] wr8_data,
    input  logic              wr16_en,
    input  logic [PAIR_W-1:0] wr16_sel,
    input  logic [WIDE_W-1:0] wr16_data,
    input  logic              xchg_af,
    input  logic              xchg_gen
);

    bank_sel_t bank_q;
    logic      acc_bank;
    logic      gen_bank;

    assign acc_bank = bank_q.acc;
    assign gen_bank = bank_q.gen;

    rfb_bank_select u_sel (
        .clk      (clk),
        .rst      (rst),
        .xchg_af  (xchg_af),
        .xchg_gen (xchg_gen),
        .sel_q    (bank_q)
    );

    rfb_storage u_store (
        .clk       (clk),
        .sel       (bank_q),
        .wr8_en    (wr8_en),
        .wr8_sel   (wr8_sel),
        .wr8_data  (wr8_data),
        .wr16_en   (wr16_en),
        .wr16_sel  (wr16_sel),
        .wr16_data (wr16_data),
        .rd8_sel   (rd8_sel),
        .rd8_data  (rd8_data),
        .rd16_sel  (rd16_sel),
        .rd16_data (rd16_data)
    );

endmodule

// File: rtl/rfb_checker.sv
module rfb_checker
    import rfb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] rd8_sel,
    input logic [DATA_W-1:0] rd8_data,
    input logic [PAIR_W-1:0] rd16_sel,
    input logic [WIDE_W-1:0] rd16_data,
    input logic              wr8_en,
    input logic [CODE_W-1:0] wr8_sel,
    input logic [DATA_W-1:0] wr8_data,
    input logic              wr16_en,
    input logic [PAIR_W-1:0] wr16_sel,
    input logic [WIDE_W-1:0] wr16_data,
    input logic              xchg_af,
    input logic              xchg_gen,
    input logic              acc_bank,
    input logic              gen_bank
);

    logic quiet;
    assign quiet = !xchg_af && !xchg_gen;

    // R1: an idle cycle keeps the read data
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!wr8_en && !wr16_en && quiet)
         && $stable(rd8_sel) && $stable(rd16_sel))
        |-> ($stable(rd8_data) && $stable(rd16_data)));

    // R2: byte and pair ports agree on a shared pair
    assert_pair_bytes_R2: assert property (@(posedge clk) disable iff (rst)
        (pair_of(rd8_sel) == rd16_sel) |-> (rd8_data == wide_byte(rd16_data, rd8_sel)));

    // R3: a plain byte write is visible after the edge
    assert_byte_write_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr8_en && quiet)
         && $past(!(wr16_en && wr16_sel == pair_of(wr8_sel)))
         && rd8_sel == $past(wr8_sel))
        |-> (rd8_data == $past(wr8_data)));

    // R4: a plain pair write is visible after the edge
    assert_wide_write_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr16_en && quiet) && rd16_sel == $past(wr16_sel))
        |-> (rd16_data == $past(wr16_data)));

    // R5: the pair write wins a collision
    assert_wide_wins_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr8_en && wr16_en && quiet)
         && $past(wr16_sel == pair_of(wr8_sel)) && rd8_sel == $past(wr8_sel))
        |-> (rd8_data == wide_byte($past(wr16_data), rd8_sel)));

    // R6: the general command flips only the general select
    assert_gen_flip_R6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((gen_bank != $past(gen_bank)) == $past(xchg_gen)));

    // R7: the accumulator command flips only the accumulator select
    assert_acc_flip_R7: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((acc_bank != $past(acc_bank)) == $past(xchg_af)));

    // R9: reset leaves both selects on the primary copy
    assert_reset_primary_R9: assert property (@(posedge clk)
        $past(rst) |-> (!acc_bank && !gen_bank));

endmodule

bind dual_bank_regfile rfb_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd8_sel   (rd8_sel),
    .rd8_data  (rd8_data),
    .rd16_sel  (rd16_sel),
    .rd16_data (rd16_data),
    .wr8_en    (wr8_en),
    .wr8_sel   (wr8_sel),
    .wr8_data  (wr8_data),
    .wr16_en   (wr16_en),
    .wr16_sel  (wr16_sel),
    .wr16_data (wr16_data),
    .xchg_af   (xchg_af),
    .xchg_gen  (xchg_gen),
    .acc_bank  (acc_bank),
    .gen_bank  (gen_bank)
);

// File: tb/dual_bank_regfile_bench.sv
`timescale 1ns/1ps
module dual_bank_regfile_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  rd8_sel = '0;
    logic [7:0]  rd8_data;
    logic [1:0]  rd16_sel = '0;
    logic [15:0] rd16_data;
    logic        wr8_en = 1'b0;
    logic [2:0]  wr8_sel = '0;
    logic [7:0]  wr8_data = '0;
    logic        wr16_en = 1'b0;
    logic [1:0]  wr16_sel = '0;
    logic [15:0] wr16_data = '0;
    logic        xchg_af = 1'b0;
    logic        xchg_gen = 1'b0;

    int applied = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dual_bank_regfile u_dual_bank_regfile (
        .clk(clk), .rst(rst),
        .rd8_sel(rd8_sel), .rd8_data(rd8_data),
        .rd16_sel(rd16_sel), .rd16_data(rd16_data),
        .wr8_en(wr8_en), .wr8_sel(wr8_sel), .wr8_data(wr8_data),
        .wr16_en(wr16_en), .wr16_sel(wr16_sel), .wr16_data(wr16_data),
        .xchg_af(xchg_af), .xchg_gen(xchg_gen)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        w8;
        logic [2:0]  s8;
        logic [7:0]  d8;
        logic        w16;
        logic [1:0]  s16;
        logic [15:0] d16;
        logic        xa;
        logic        xg;
        logic [1:0]  rsel;
        logic [15:0] exp16;
    } vec_t;

    localparam int NV = 23;
    // pair codes: 0=BC 1=DE 2=HL 3=AF; reg codes: 0=B 1=C 4=H 5=L 6=A 7=F
    localparam vec_t VEC [NV] = '{
        '{4'd4, 1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 16'h1122, 1'b0, 1'b0, 2'd0, 16'h1122}, // R4
        '{4'd4, 1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 16'h3344, 1'b0, 1'b0, 2'd1, 16'h3344}, // R4
        '{4'd4, 1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 16'h5566, 1'b0, 1'b0, 2'd2, 16'h5566}, // R4
        '{4'd4, 1'b0, 3'd0, 8'h00, 1'b1, 2'd3, 16'h7788, 1'b0, 1'b0, 2'd3, 16'h7788}, // R4
        '{4'd6, 1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd3, 16'h7788}, // R6 AF kept
        '{4'd4, 1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 16'hA1A2, 1'b0, 1'b0, 2'd0, 16'hA1A2}, // R4 shadow
        '{4'd4, 1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 16'hB1B2, 1'b0, 1'b0, 2'd1, 16'hB1B2}, // R4
        '{4'd4, 1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 16'hC1C2, 1'b0, 1'b0, 2'd2, 16'hC1C2}, // R4
        '{4'd7, 1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 2'd0, 16'hA1A2}, // R7 BC kept
        '{4'd4, 1'b0, 3'd0, 8'h00, 1'b1, 2'd3, 16'hD1D2, 1'b0, 1'b0, 2'd3, 16'hD1D2}, // R4
        '{4'd6, 1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd2, 16'h5566}, // R6 swap back
        '{4'd6, 1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd1, 16'h3344}, // R6 DE too
        '{4'd7, 1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 2'd3, 16'h7788}, // R7
        '{4'd3, 1'b1, 3'd1, 8'h5A, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd0, 16'h115A}, // R3 low byte
        '{4'd5, 1'b1, 3'd6, 8'hE0, 1'b1, 2'd3, 16'h0F0F, 1'b0, 1'b0, 2'd3, 16'h0F0F}, // R5
        '{4'd3, 1'b1, 3'd0, 8'h3C, 1'b1, 2'd1, 16'h4455, 1'b0, 1'b0, 2'd0, 16'h3C5A}, // R3 high byte
        '{4'd4, 1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd1, 16'h4455}, // R4 same cycle
        '{4'd8, 1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 16'hABCD, 1'b0, 1'b1, 2'd2, 16'hC1C2}, // R8 hidden now
        '{4'd8, 1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd2, 16'hABCD}, // R8 revealed
        '{4'd8, 1'b1, 3'd7, 8'h66, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 2'd3, 16'hD1D2}, // R8 byte
        '{4'd8, 1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 2'd3, 16'h0F66}, // R8
        '{4'd7, 1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 2'd0, 16'hA1A2}, // R7 both
        '{4'd7, 1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd3, 16'hD1D2}  // R7 both
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        applied++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read8(input string tag, input logic [2:0] code, input logic [7:0] exp);
        @(negedge clk);
        rd8_sel = code;
        #1;
        check(tag, {8'h00, rd8_data}, {8'h00, exp});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr8_en    = VEC[i].w8;
            wr8_sel   = VEC[i].s8;
            wr8_data  = VEC[i].d8;
            wr16_en   = VEC[i].w16;
            wr16_sel  = VEC[i].s16;
            wr16_data = VEC[i].d16;
            xchg_af   = VEC[i].xa;
            xchg_gen  = VEC[i].xg;
            rd16_sel  = VEC[i].rsel;
            @(posedge clk);
            #1;
            check($sformatf("R%0d vector %0d", VEC[i].req, i), rd16_data, VEC[i].exp16);
        end

        @(negedge clk);
        wr8_en = 1'b0; wr16_en = 1'b0; xchg_af = 1'b0; xchg_gen = 1'b0;

        // R9: both selects are 1 here; reset must bring back the primary copies
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd16_sel = 2'd3;
        #1;
        check("R9 AF primary", rd16_data, 16'h0F66);
        rd16_sel = 2'd0;
        #1;
        check("R9 BC primary", rd16_data, 16'h3C5A);
        rd16_sel = 2'd2;
        #1;
        check("R9 HL primary", rd16_data, 16'hABCD);

        // R1 / R2: byte view of the primary copies
        read8("R1 A", 3'd6, 8'h0F);
        read8("R1 F", 3'd7, 8'h66);
        read8("R2 B high", 3'd0, 8'h3C);
        read8("R2 L low", 3'd5, 8'hCD);
        read8("R2 E low", 3'd3, 8'h55);

        // R1: idle cycles keep contents
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd16_sel = 2'd1;
        #1;
        check("R1 DE held", rd16_data, 16'h4455);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end

endmodule